// File: doc/BRIEF.md
# Routable Interrupt Controller with Software Sources

The block gathers a bank of level-sensitive hardware interrupt inputs and a bank of software-raised interrupt sources into one pending vector. Every source, hardware or software, owns a 64-bit configuration word. That word holds an enable bit, a target thread identifier field and a route field. The route field picks which of a small set of processor-facing interrupt lines the source drives. Each output line is the OR of all sources that are pending, enabled and routed to it.

Software drives the block through a single-cycle register port. Each access carries a request, a write enable, a word address and 64 bits of write data. The address has two fields: a 2-bit window code on top and a word index below it. There are four windows: configuration, pending readback, write-one-to-set and write-one-to-clear. Hardware sources take the low indices, in groups of 64. Software sources start at the first index after the hardware groups, and with the default sizes that index is 64. Software sources are raised through the set window and lowered through the clear window.

Top module: `ric_top`

## Requirements
- R1: The configuration word of source s is at window code 0, word index s. Its fields are: enable in bit 31, thread identifier in bits 30:8, route in bits 3:0. A read returns these fields, and every other bit reads as zero whatever was written there.
- R2: A synchronous active-high reset clears every configuration word, every software pending bit and the read-data register. After reset all interrupt outputs are low.
- R3: Window code 1, word g returns pending group g. Word 0 returns the hardware input levels after a two-flop synchronizer, so an input change is visible to the outputs after two clock edges and not after one.
- R4: A write to window code 2 at word 1 sets pending bit 64+n for each 1 in data bit n. Bits already set stay set.
- R5: A write to window code 3 at word 1 clears pending bit 64+n for each 1 in data bit n. Other bits keep their value.
- R6: A write to the set or clear window at word 0, which is a hardware group, changes no pending bit.
- R7: Output line k is high exactly when at least one source is pending, has its enable bit set and has route equal to k. Several sources on one line combine by OR.
- R8: A source whose route is 6 or more, with the default six outputs, drives no output line.
- R9: A source with its enable bit clear drives no output, even when it is pending and has a non-zero route or thread identifier.
- R10: Read data is registered. It updates on the clock edge that takes a read request and holds its value across write accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Register access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (9) | {window code[1:0], word index} |
| wdata | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| hw_irq_i | input | 64*N_HW_GRP | Hardware interrupt levels |
| irq_o | output | N_OUT (6) | Interrupt lines to the processor |

## Verification
The bench checks field packing on readback by writing all ones to a configuration word: any reserved bit that reads back as one shows a wrong mask. It checks that set and clear accumulate instead of overwrite; a design that loaded the mask directly would lose bit 0x80... or keep bits the clear did not name. Writes to the hardware group of the set and clear windows must leave the software bits alone, and a design that failed to subtract the hardware group count would corrupt them. On the output side the bench covers the two-edge synchronizer latency, an out-of-range route, a disabled source that is pending, and two sources sharing one line, where a design that assigned instead of ORing would drop the line.

// File: rtl/ric_pkg.sv
package ric_pkg;

    localparam int GRP_W   = 64;
    localparam int TID_W   = 23;
    localparam int ROUTE_W = 4;

    typedef enum logic [1:0] {
        WIN_CFG  = 2'd0,
        WIN_PEND = 2'd1,
        WIN_SET  = 2'd2,
        WIN_CLR  = 2'd3
    } ric_win_e;

    typedef struct packed {
        logic               en;
        logic [TID_W-1:0]   tid;
        logic [ROUTE_W-1:0] route;
    } ric_cfg_t;

    // Enable at 31, thread id at 30:8, route at 3:0; all else zero.
    function automatic logic [GRP_W-1:0] cfg_to_word(ric_cfg_t c);
        logic [GRP_W-1:0] w;
        w        = '0;
        w[31]    = c.en;
        w[30:8]  = c.tid;
        w[3:0]   = c.route;
        return w;
    endfunction

    function automatic ric_cfg_t word_to_cfg(logic [GRP_W-1:0] w);
        ric_cfg_t c;
        c.en    = w[31];
        c.tid   = w[30:8];
        c.route = w[3:0];
        return c;
    endfunction

endpackage

// File: rtl/ric_cfg_bank.sv
module ric_cfg_bank
    import ric_pkg::*;
#(
    parameter int N_SRC = 128,
    parameter int IDX_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [GRP_W-1:0]     wr_word,
    output ric_cfg_t             cfg_o [N_SRC]
);

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_o[s] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(s)) begin
                cfg_o[s] <= word_to_cfg(wr_word);
            end
        end
    end

endmodule

// File: rtl/ric_pend.sv
module ric_pend
    import ric_pkg::*;
#(
    parameter int N_HW_GRP = 1,
    parameter int N_SW_GRP = 1,
    parameter int IDX_W    = 7,
    localparam int N_HW    = GRP_W * N_HW_GRP,
    localparam int N_SW    = GRP_W * N_SW_GRP
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_HW-1:0]    hw_irq_i,
    input  logic               set_en,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   grp_idx,
    input  logic [GRP_W-1:0]   mask,
    output logic [N_HW-1:0]    hw_lvl,
    output logic [N_SW-1:0]    sw_pend
);

    logic [N_HW-1:0] hw_meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_meta <= '0;
            hw_lvl  <= '0;
        end else begin
            hw_meta <= hw_irq_i;
            hw_lvl  <= hw_meta;
        end
    end

    for (genvar g = 0; g < N_SW_GRP; g++) begin : g_sw
        logic hit;
        assign hit = (grp_idx == IDX_W'(N_HW_GRP + g));
        always_ff @(posedge clk) begin
            if (rst) begin
                sw_pend[g*GRP_W +: GRP_W] <= '0;
            end else if (hit && set_en) begin
                sw_pend[g*GRP_W +: GRP_W] <= sw_pend[g*GRP_W +: GRP_W] | mask;
            end else if (hit && clr_en) begin
                sw_pend[g*GRP_W +: GRP_W] <= sw_pend[g*GRP_W +: GRP_W] & ~mask;
            end
        end
    end

endmodule

// File: rtl/ric_route.sv
module ric_route
    import ric_pkg::*;
#(
    parameter int N_SRC = 128,
    parameter int N_OUT = 6
) (
    input  logic [N_SRC-1:0] pend,
    input  ric_cfg_t         cfg   [N_SRC],
    output logic [N_OUT-1:0] irq_o
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_line
        always_comb begin
            irq_o[k] = 1'b0;
            for (int s = 0; s < N_SRC; s++) begin
                if (pend[s] && cfg[s].en && cfg[s].route == ROUTE_W'(k)) begin
                    irq_o[k] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ric_top.sv
module ric_top
    import ric_pkg::*;
#(
    parameter int N_HW_GRP = 1,
    parameter int N_SW_GRP = 1,
    parameter int N_OUT    = 6,
    parameter int ADDR_W   = 2 + $clog2(64 * (N_HW_GRP + N_SW_GRP))
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [63:0]               wdata,
    output logic [63:0]               rd_data,
    input  logic [64*N_HW_GRP-1:0]    hw_irq_i,
    output logic [N_OUT-1:0]          irq_o
);

    localparam int N_GRP = N_HW_GRP + N_SW_GRP;
    localparam int N_HW  = GRP_W * N_HW_GRP;
    localparam int N_SW  = GRP_W * N_SW_GRP;
    localparam int N_SRC = N_HW + N_SW;
    localparam int IDX_W = ADDR_W - 2;

    ric_win_e         win;
    logic [IDX_W-1:0] idx;
    assign win = ric_win_e'(addr[ADDR_W-1 -: 2]);
    assign idx = addr[IDX_W-1:0];

    ric_cfg_t         cfg [N_SRC];
    logic [N_HW-1:0]  hw_lvl;
    logic [N_SW-1:0]  sw_pend;
    logic [N_SRC-1:0] pend_all;

    assign pend_all = {sw_pend, hw_lvl};

    ric_cfg_bank #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req && we && win == WIN_CFG),
        .wr_idx  (idx),
        .wr_word (wdata),
        .cfg_o   (cfg)
    );

    ric_pend #(.N_HW_GRP(N_HW_GRP), .N_SW_GRP(N_SW_GRP), .IDX_W(IDX_W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .hw_irq_i (hw_irq_i),
        .set_en   (req && we && win == WIN_SET),
        .clr_en   (req && we && win == WIN_CLR),
        .grp_idx  (idx),
        .mask     (wdata),
        .hw_lvl   (hw_lvl),
        .sw_pend  (sw_pend)
    );

    ric_route #(.N_SRC(N_SRC), .N_OUT(N_OUT)) u_route (
        .pend  (pend_all),
        .cfg   (cfg),
        .irq_o (irq_o)
    );

    logic [63:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (win == WIN_CFG) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (idx == IDX_W'(s)) rd_next = cfg_to_word(cfg[s]);
            end
        end else if (win == WIN_PEND) begin
            for (int g = 0; g < N_GRP; g++) begin
                if (idx == IDX_W'(g)) rd_next = pend_all[g*GRP_W +: GRP_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (req && !we) begin
            rd_data <= rd_next;
        end
    end

endmodule

// File: rtl/ric_chk.sv
module ric_chk #(
    parameter int N_HW_GRP = 1,
    parameter int N_SW     = 64,
    parameter int N_OUT    = 6,
    parameter int ADDR_W   = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [63:0]       wdata,
    input logic [63:0]       rd_data,
    input logic [N_OUT-1:0]  irq_o,
    input logic [N_SW-1:0]   sw_pend
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] SET_SW = {2'd2, IDX_W'(N_HW_GRP)};
    localparam logic [ADDR_W-1:0] CLR_SW = {2'd3, IDX_W'(N_HW_GRP)};
    localparam logic [ADDR_W-1:0] SET_HW = {2'd2, IDX_W'(0)};
    localparam logic [ADDR_W-1:0] CLR_HW = {2'd3, IDX_W'(0)};

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (irq_o == '0 && sw_pend == '0)); // R2

    AST_CFG_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req && !we && addr[ADDR_W-1 -: 2] == 2'd0)
        |=> (rd_data[63:32] == '0 && rd_data[7:4] == '0)); // R1

    AST_SET_ACCUM: assert property (@(posedge clk) disable iff (rst)
        (req && we && addr == SET_SW)
        |=> ((sw_pend[63:0] & $past(wdata)) == $past(wdata)
             && (sw_pend[63:0] & $past(sw_pend[63:0])) == $past(sw_pend[63:0]))); // R4

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (req && we && addr == CLR_SW)
        |=> (sw_pend[63:0] == ($past(sw_pend[63:0]) & ~$past(wdata)))); // R5

    AST_HW_WORD_INERT: assert property (@(posedge clk) disable iff (rst)
        (req && we && (addr == SET_HW || addr == CLR_HW))
        |=> $stable(sw_pend)); // R6

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req && we) |=> $stable(rd_data)); // R10

endmodule

bind ric_top ric_chk #(
    .N_HW_GRP (N_HW_GRP),
    .N_SW     (64 * N_SW_GRP),
    .N_OUT    (N_OUT),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .we      (we),
    .addr    (addr),
    .wdata   (wdata),
    .rd_data (rd_data),
    .irq_o   (irq_o),
    .sw_pend (sw_pend)
);

// File: tb/ric_top_tb.sv
module ric_top_tb;

    localparam int ADDR_W = 9;
    localparam int N_OUT  = 6;
    localparam int NV     = 14;

    logic              clk = 1'b0;
    logic              rst;
    logic              req;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [63:0]       wdata;
    logic [63:0]       rd_data;
    logic [63:0]       hw_irq_i;
    logic [N_OUT-1:0]  irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    ric_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .we       (we),
        .addr     (addr),
        .wdata    (wdata),
        .rd_data  (rd_data),
        .hw_irq_i (hw_irq_i),
        .irq_o    (irq_o)
    );

    // {req tag[3:0], we, addr[8:0], data[63:0], expected[63:0]}
    localparam logic [141:0] VEC [NV] = '{
        {4'd1, 1'b1, 9'h005, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {4'd1, 1'b0, 9'h005, 64'h0, 64'h0000_0000_FFFF_FF0F},
        {4'd2, 1'b0, 9'h006, 64'h0, 64'h0},
        {4'd4, 1'b1, 9'h101, 64'h0000_0000_0000_00A5, 64'h0},
        {4'd4, 1'b0, 9'h081, 64'h0, 64'h0000_0000_0000_00A5},
        {4'd4, 1'b1, 9'h101, 64'h8000_0000_0000_0000, 64'h0},
        {4'd4, 1'b0, 9'h081, 64'h0, 64'h8000_0000_0000_00A5},
        {4'd5, 1'b1, 9'h181, 64'h0000_0000_0000_0005, 64'h0},
        {4'd5, 1'b0, 9'h081, 64'h0, 64'h8000_0000_0000_00A0},
        {4'd6, 1'b1, 9'h100, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {4'd6, 1'b0, 9'h081, 64'h0, 64'h8000_0000_0000_00A0},
        {4'd3, 1'b0, 9'h080, 64'h0, 64'h0},
        {4'd6, 1'b1, 9'h180, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {4'd6, 1'b0, 9'h081, 64'h0, 64'h8000_0000_0000_00A0}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [ADDR_W-1:0] a, input logic [63:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        rst = 1'b1; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; hw_irq_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        check("R2 irq after reset", 64'(irq_o), 64'h0);
        check("R2 rd_data after reset", rd_data, 64'h0);
        access(1'b0, 9'h000, 64'h0);
        check("R2 cfg0 after reset", rd_data, 64'h0);
        access(1'b0, 9'h081, 64'h0);
        check("R2 soft pending after reset", rd_data, 64'h0);

        // Vector table: R1 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][137], VEC[i][136:128], VEC[i][127:64]);
            if (!VEC[i][137]) begin
                check($sformatf("R%0d vector %0d", VEC[i][141:138], i), rd_data, VEC[i][63:0]);
            end
        end
        access(1'b1, 9'h181, 64'hFFFF_FFFF_FFFF_FFFF);
        access(1'b1, 9'h005, 64'h0);

        // R10: rd_data holds across writes
        access(1'b0, 9'h081, 64'h0);
        held = rd_data;
        access(1'b1, 9'h101, 64'h0000_0000_0000_0001);
        check("R10 rd_data held over write", rd_data, held);
        access(1'b1, 9'h181, 64'h0000_0000_0000_0001);

        // R3 + R7: hardware source 3 on line 2, two-edge latency
        access(1'b1, 9'h003, 64'h0000_0000_8000_0002);
        hw_irq_i[3] = 1'b1;
        @(negedge clk);
        check("R3 one edge not yet visible", 64'(irq_o), 64'h0);
        @(negedge clk);
        check("R3 R7 hw source on line 2", 64'(irq_o), 64'h04);
        access(1'b0, 9'h080, 64'h0);
        check("R3 hw level readback", rd_data, 64'h8);

        // R7: soft source 64+7 on line 5
        access(1'b1, 9'h047, 64'h0000_0000_8000_0005);
        check("R7 routed but not pending", 64'(irq_o), 64'h04);
        access(1'b1, 9'h101, 64'h0000_0000_0000_0080);
        check("R7 soft source on line 5", 64'(irq_o), 64'h24);

        // R8: route 6 and 15 drive nothing
        access(1'b1, 9'h00A, 64'h0000_0000_8000_0006);
        access(1'b1, 9'h00C, 64'h0000_0000_8000_000F);
        hw_irq_i[10] = 1'b1; hw_irq_i[12] = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 out-of-range route", 64'(irq_o), 64'h24);

        // R9: disabled source with route and tid drives nothing
        access(1'b1, 9'h00B, 64'h0000_0000_7FFF_FF01);
        hw_irq_i[11] = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 disabled pending source", 64'(irq_o), 64'h24);

        // R5: clear soft 7 drops line 5
        access(1'b1, 9'h181, 64'h0000_0000_0000_0080);
        check("R5 clear drops line 5", 64'(irq_o), 64'h04);

        // R7: two sources share line 2 (OR)
        access(1'b1, 9'h041, 64'h0000_0000_8000_0002);
        access(1'b1, 9'h101, 64'h0000_0000_0000_0002);
        hw_irq_i[3] = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 shared line kept by soft source", 64'(irq_o), 64'h04);
        access(1'b1, 9'h181, 64'h0000_0000_0000_0002);
        check("R7 shared line released", 64'(irq_o), 64'h00);

        // R2: reset mid-run clears configuration and pending
        access(1'b1, 9'h101, 64'h0000_0000_0000_0002);
        check("R7 line 2 before reset", 64'(irq_o), 64'h04);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R2 irq after second reset", 64'(irq_o), 64'h0);
        access(1'b0, 9'h041, 64'h0);
        check("R2 cfg cleared by reset", rd_data, 64'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule